// File: doc/BRIEF.md
# Supply Undervoltage Reset Sequencer

This block is the digital half of a supply supervisor. An external comparator reports that the monitored supply has dropped below its undervoltage threshold. A second comparator reports a deep brownout. An internal ramp oscillator supplies one strobe per full period. From these inputs the block drives two active-low outputs. The first is an early warning that a processor can treat as a non-maskable interrupt. The second is a slower system reset, which follows only when the warning persists.

The warning falls only after the undervoltage flag has been present for a filter time. When the internal threshold is in use, that time shrinks as the reported depth of the dip grows. When an external divider sets the threshold, the time is a fixed constant. A deep brownout skips the filter. On recovery the warning stays low for an initial ramp interval and then for a fixed number of oscillator periods. Any new dip during that wait restarts it. The reset output follows the warning once the warning has been low long enough, and it is released one clock after the warning rises.

All times are counted in system clock cycles or in oscillator strobes. The analog comparators, the capacitor ramp and the driver slew are represented by the inputs and by parameters.

Top module: `uvs_supervisor`

## Requirements
- R1: While `rst` is high both outputs are low. After reset the warning stays low until a complete release sequence (R6) has finished.
- R2: With `ext_sel`=0 and the warning high, the warning falls at the N-th consecutive rising clock edge that samples `uv_flag` high. N = INT_FILT >> `uv_lvl`, where `uv_lvl` is 0 (shallow) to 3 (deepest). With the defaults N is 32, 16, 8 or 4.
- R3: With `ext_sel`=1, N = EXT_FILT (default 20) for every value of `uv_lvl`.
- R4: An edge that samples `uv_flag` low before N is reached clears the filter, so a shorter dip leaves the warning high.
- R5: While the warning is high, the first edge that samples `deep_flag` high drives the warning low.
- R6: While the warning is low, once both flags are sampled low the block counts RAMP_CYC edges (default 8) and ignores ticks during that time. It then counts `osc_tick` strobes. The warning rises at the edge that samples the PERIODS-th strobe (default 127).
- R7: An edge that samples `uv_flag` or `deep_flag` high during the release sequence restarts it from the start of the ramp.
- R8: The reset falls at the edge that samples the warning low for the RST_FILT-th consecutive time (default 200). A warning pulse shorter than RST_FILT cycles causes no reset.
- R9: The reset rises at the first edge that samples the warning high, which is one cycle after the warning rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_flag | input | 1 | Supply below undervoltage threshold |
| deep_flag | input | 1 | Supply below deep-brownout level |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| ext_sel | input | 1 | 1: external divider threshold, fixed filter; 0: internal, depth-dependent filter |
| uv_lvl | input | LVL_W | Dip depth code, 0 shallow to 3 deep |
| warn_n | output | 1 | Active-low early warning |
| sys_rst_n | output | 1 | Active-low delayed system reset |

## Verification
The bench targets these boundaries:
- A dip one cycle shorter than the filter, which a filter with an off-by-one error would trip on.
- Depth changes and the external mode, where a wrong shift or an ignored mux would give the wrong delay.
- A dip that returns in the middle of the release sequence, where a design that does not restart would release early.
- Ticks that arrive during the ramp, where a design that counts them would release early.
- A warning pulse shorter than the reset filter, which must not reach the reset, and a longer one, which must.
- The one-cycle reset release after the warning rises, where a stray register stage would add delay.

// File: rtl/uvs_pkg.sv
package uvs_pkg;

    typedef enum logic {
        PH_RAMP  = 1'b0,
        PH_COUNT = 1'b1
    } rec_phase_e;

    typedef struct packed {
        logic       ext_sel;
        logic [1:0] lvl;
    } filt_cfg_t;

    // Filter length in cycles for the current threshold source and dip depth.
    function automatic int filt_target(input filt_cfg_t cfg, input int int_filt,
                                       input int ext_filt);
        int t;
        if (cfg.ext_sel) begin
            t = ext_filt;
        end else begin
            t = int_filt >> cfg.lvl;
        end
        if (t < 1) t = 1;
        return t;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/uvs_filter.sv
module uvs_filter
    import uvs_pkg::*;
#(
    parameter int INT_FILT = 32,
    parameter int EXT_FILT = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      uv,
    input  logic      deep,
    input  filt_cfg_t cfg,
    output logic      trip
);
    localparam int CW = $clog2(max2(INT_FILT, EXT_FILT) + 1);

    logic [CW-1:0] run_q;
    int            tgt;
    logic          reached;

    always_comb begin
        tgt     = filt_target(cfg, INT_FILT, EXT_FILT);
        reached = (int'(run_q) >= (tgt - 1));
        trip    = en && (deep || (uv && reached));
    end

    always_ff @(posedge clk) begin
        if (rst || !en || !uv || trip) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/uvs_recover.sv
module uvs_recover
    import uvs_pkg::*;
#(
    parameter int RAMP_CYC = 8,
    parameter int PERIODS  = 127
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic hold,
    input  logic tick,
    output logic done
);
    localparam int RW = $clog2(RAMP_CYC + 1);
    localparam int TW = $clog2(PERIODS + 1);
    localparam logic [RW-1:0] RAMP_LAST = RW'(RAMP_CYC - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(PERIODS - 1);

    rec_phase_e    phase_q;
    logic [RW-1:0] ramp_q;
    logic [TW-1:0] tick_q;

    always_comb begin
        done = en && !hold && (phase_q == PH_COUNT) && tick && (tick_q == TICK_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !en || hold) begin
            phase_q <= PH_RAMP;
            ramp_q  <= '0;
            tick_q  <= '0;
        end else if (phase_q == PH_RAMP) begin
            if (ramp_q == RAMP_LAST) begin
                phase_q <= PH_COUNT;
            end else begin
                ramp_q <= ramp_q + 1'b1;
            end
        end else if (tick && !done) begin
            tick_q <= tick_q + 1'b1;
        end
    end

endmodule

// File: rtl/uvs_rst_stage.sv
module uvs_rst_stage #(
    parameter int RST_FILT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic warn_n,
    output logic sys_rst_n
);
    localparam int FW = $clog2(RST_FILT + 1);
    localparam logic [FW-1:0] LOW_LAST = FW'(RST_FILT - 1);

    logic [FW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q     <= '0;
            sys_rst_n <= 1'b0;
        end else if (warn_n) begin
            low_q     <= '0;
            sys_rst_n <= 1'b1;
        end else if (low_q == LOW_LAST) begin
            sys_rst_n <= 1'b0;
        end else begin
            low_q <= low_q + 1'b1;
        end
    end

endmodule

// File: rtl/uvs_supervisor.sv
module uvs_supervisor
    import uvs_pkg::*;
#(
    parameter int LVL_W    = 2,
    parameter int INT_FILT = 32,
    parameter int EXT_FILT = 20,
    parameter int RAMP_CYC = 8,
    parameter int PERIODS  = 127,
    parameter int RST_FILT = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uv_flag,
    input  logic             deep_flag,
    input  logic             osc_tick,
    input  logic             ext_sel,
    input  logic [LVL_W-1:0] uv_lvl,
    output logic             warn_n,
    output logic             sys_rst_n
);
    filt_cfg_t cfg;
    logic      trip;
    logic      done;
    logic      hold;

    always_comb begin
        cfg.ext_sel = ext_sel;
        cfg.lvl     = 2'(uv_lvl);
        hold        = uv_flag || deep_flag;
    end

    uvs_filter #(
        .INT_FILT (INT_FILT),
        .EXT_FILT (EXT_FILT)
    ) u_filter (
        .clk  (clk),
        .rst  (rst),
        .en   (warn_n),
        .uv   (uv_flag),
        .deep (deep_flag),
        .cfg  (cfg),
        .trip (trip)
    );

    uvs_recover #(
        .RAMP_CYC (RAMP_CYC),
        .PERIODS  (PERIODS)
    ) u_recover (
        .clk  (clk),
        .rst  (rst),
        .en   (!warn_n),
        .hold (hold),
        .tick (osc_tick),
        .done (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            warn_n <= 1'b0;
        end else if (warn_n && trip) begin
            warn_n <= 1'b0;
        end else if (!warn_n && done) begin
            warn_n <= 1'b1;
        end
    end

    uvs_rst_stage #(
        .RST_FILT (RST_FILT)
    ) u_rst_stage (
        .clk       (clk),
        .rst       (rst),
        .warn_n    (warn_n),
        .sys_rst_n (sys_rst_n)
    );

endmodule

// File: rtl/uvs_sup_chk.sv
module uvs_sup_chk (
    input logic clk,
    input logic rst,
    input logic uv_flag,
    input logic deep_flag,
    input logic osc_tick,
    input logic warn_n,
    input logic sys_rst_n
);
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1
    always @(posedge clk) begin
        if (rst_seen_q) begin
            reset_low_chk: assert (!warn_n && !sys_rst_n)
                else $error("outputs not low after reset");
        end
    end

    // R5
    deep_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (deep_flag && warn_n) |=> !warn_n);

    // R4
    fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(warn_n) |-> $past(uv_flag || deep_flag));

    // R6
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(warn_n) |-> ($past(osc_tick) && !$past(uv_flag) && !$past(deep_flag)));

    // R8
    rst_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_n) |-> (!warn_n && !$past(warn_n)));

    // R9
    rst_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> $past(warn_n));

endmodule

bind uvs_supervisor uvs_sup_chk u_sup_chk (
    .clk       (clk),
    .rst       (rst),
    .uv_flag   (uv_flag),
    .deep_flag (deep_flag),
    .osc_tick  (osc_tick),
    .warn_n    (warn_n),
    .sys_rst_n (sys_rst_n)
);

// File: tb/uvs_supervisor_test.sv
`timescale 1ns/1ps
module uvs_supervisor_test;
    localparam int INT_FILT = 32;
    localparam int EXT_FILT = 20;
    localparam int RAMP_CYC = 8;
    localparam int PERIODS  = 127;
    localparam int RST_FILT = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv_flag = 1'b0;
    logic       deep_flag = 1'b0;
    logic       osc_tick = 1'b0;
    logic       ext_sel = 1'b0;
    logic [1:0] uv_lvl = 2'd0;
    logic       warn_n;
    logic       sys_rst_n;

    int    total = 0;
    int    bad = 0;
    int    tick_per = 0;
    string tag = "R1";

    // reference state
    logic m_warn = 1'b0;
    logic m_rst = 1'b0;
    int   m_dip = 0;
    int   m_clear = 0;
    int   m_ticks = 0;
    int   m_low = 0;

    always #2 clk = ~clk;

    uvs_supervisor #(
        .LVL_W (2), .INT_FILT (INT_FILT), .EXT_FILT (EXT_FILT),
        .RAMP_CYC (RAMP_CYC), .PERIODS (PERIODS), .RST_FILT (RST_FILT)
    ) uut (
        .clk (clk), .rst (rst), .uv_flag (uv_flag), .deep_flag (deep_flag),
        .osc_tick (osc_tick), .ext_sel (ext_sel), .uv_lvl (uv_lvl),
        .warn_n (warn_n), .sys_rst_n (sys_rst_n)
    );

    function automatic int need_cycles(input logic ext, input logic [1:0] lvl);
        return ext ? EXT_FILT : (INT_FILT >> lvl);
    endfunction

    // Reference built from the requirement text.
    always @(posedge clk) begin
        logic was_warn;
        was_warn = m_warn;
        if (rst) begin
            m_warn = 0; m_rst = 0; m_dip = 0; m_clear = 0; m_ticks = 0; m_low = 0;
        end else begin
            if (m_warn) begin
                if (deep_flag) begin
                    m_warn = 0; m_dip = 0;
                end else if (uv_flag) begin
                    m_dip = m_dip + 1;
                    if (m_dip >= need_cycles(ext_sel, uv_lvl)) begin
                        m_warn = 0; m_dip = 0;
                    end
                end else begin
                    m_dip = 0;
                end
                m_clear = 0; m_ticks = 0;
            end else begin
                if (uv_flag || deep_flag) begin
                    m_clear = 0; m_ticks = 0;
                end else if (m_clear < RAMP_CYC) begin
                    m_clear = m_clear + 1;
                end else if (osc_tick) begin
                    m_ticks = m_ticks + 1;
                    if (m_ticks == PERIODS) begin
                        m_warn = 1; m_dip = 0;
                    end
                end
            end
            if (was_warn) begin
                m_rst = 1; m_low = 0;
            end else begin
                m_low = m_low + 1;
                if (m_low >= RST_FILT) m_rst = 0;
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, warn_n, m_warn, "warn_n");
            chk(tag, sys_rst_n, m_rst, "sys_rst_n");
            osc_tick = (tick_per != 0) && (($urandom % tick_per) == 0);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: outputs low in reset and until a full release
        tag = "R1";
        run(4);
        chk("R1", warn_n, 1'b0, "warn_n in reset");
        chk("R1", sys_rst_n, 1'b0, "sys_rst_n in reset");
        @(negedge clk); rst = 1'b0;
        tick_per = 1;
        run(RAMP_CYC + 60);
        chk("R1", warn_n, 1'b0, "warn_n mid release");
        tag = "R6";
        run(200);
        chk("R6", warn_n, 1'b1, "warn_n after release");
        tag = "R9";
        run(2);
        chk("R9", sys_rst_n, 1'b1, "reset follows warning");

        // R4: one cycle short of the filter, then clear
        tag = "R4";
        ext_sel = 0; uv_lvl = 2;
        uv_flag = 1; run(7); uv_flag = 0; run(1);
        chk("R4", warn_n, 1'b1, "short dip kept warning high");
        // R2: exact internal filter length, depth 2 -> 8
        tag = "R2";
        uv_flag = 1; run(7);
        chk("R2", warn_n, 1'b1, "warn before 8th edge");
        run(1);
        chk("R2", warn_n, 1'b0, "warn at 8th edge");
        run(5); uv_flag = 0;
        // R8: fast ticks make a short pulse, no reset
        tag = "R8"; tick_per = 1;
        run(RAMP_CYC + PERIODS + 10);
        chk("R8", sys_rst_n, 1'b1, "short warning gave no reset");

        // R3: external filter ignores depth
        tag = "R3";
        ext_sel = 1; uv_lvl = 3;
        uv_flag = 1; run(EXT_FILT - 1);
        chk("R3", warn_n, 1'b1, "ext before limit");
        run(1);
        chk("R3", warn_n, 1'b0, "ext at limit");
        uv_flag = 0;
        // R7: a dip during release restarts it
        tag = "R7"; tick_per = 3;
        run(150); uv_flag = 1; run(2); uv_flag = 0;
        run(RAMP_CYC + 20);
        chk("R7", warn_n, 1'b0, "restart kept warning low");
        tag = "R8";
        run(200);
        chk("R8", sys_rst_n, 1'b0, "long warning gave reset");
        tag = "R9";
        run(600);
        chk("R9", sys_rst_n, 1'b1, "reset released");

        // R5: one-cycle deep brownout
        tag = "R5";
        deep_flag = 1; run(1); deep_flag = 0;
        chk("R5", warn_n, 1'b0, "deep trip");
        tick_per = 2; run(400);

        // random mix
        tag = "R2";
        for (int s = 0; s < 260; s++) begin
            int k;
            k = $urandom % 10;
            ext_sel = 1'($urandom % 2);
            uv_lvl = 2'($urandom % 4);
            tick_per = 1 + ($urandom % 5);
            if (k < 4) begin
                tag = "R4"; uv_flag = 1; run(1 + ($urandom % 40)); uv_flag = 0;
            end else if (k == 4) begin
                tag = "R5"; deep_flag = 1; run(1 + ($urandom % 3)); deep_flag = 0;
            end else begin
                tag = "R6"; run(50 + ($urandom % 500));
            end
        end
        finish_up();
    end

endmodule